// File: doc/BRIEF.md
# Paged flash window decoder

This block lets a processor on an ISA-style bus reach a large flash array through one small memory window. An access inside the fixed 8 KB window at C8000h–C9FFFh asserts one of eight active-low flash chip selects. The low flash address lines follow the bus address. The upper flash address lines come from a stored page number. Two bus locations just above the window, CA000h and CA001h, act as write-only registers: the first holds the 8 KB page inside a device, the second holds the device number. With eight devices of 256 pages each, 16 MB is reachable.

The strobes, address and data are sampled on a clock. All outputs are driven from that sampled copy, so every output lags the bus by one rising edge. A page register write is committed when the write strobe is seen released. It uses the address and data of the last cycle in which the strobe was low.

Top module: `pfw_window_dec`

## Requirements
- R1: After reset, all eight chip selects are high (inactive) and the stored page and device are both 0, so `flash_addr[20:13]` reads 0.
- R2: When the sampled bus shows `mem_rd_n` or `mem_wr_n` low and address bits 19:13 equal 64h (C8000h–C9FFFh), exactly one chip select is low. That chip select is `flash_cs_n[d]`, where d is the stored device number. Outputs reflect inputs sampled at the preceding rising edge.
- R3: With both strobes high, or with an address whose bits 19:13 differ from 64h (including C7FFFh, CA000h and CA001h), all chip selects are high.
- R4: `flash_addr[12:0]` equals bus address bits 12:0 sampled at the preceding rising edge, and `flash_addr[20:13]` equals the stored page.
- R5: A write cycle to CA000h stores data bits 7:0 as the page. The store happens at the rising edge after the one that first samples `mem_wr_n` high, and it uses the address and data sampled on the last low-strobe cycle.
- R6: A write cycle to CA001h stores data bits 2:0 as the device number, with the same timing as R5. Data bits 7:3 are ignored.
- R7: These accesses leave both registers unchanged:
  - a read of CA000h or CA001h;
  - a write to CA002h;
  - a write to an address in CA000h–CBFFFh whose bits 12:1 are not all zero;
  - a write inside the window.
- R8: While the write strobe stays low, the registers keep their old value, whatever the data does during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Bus memory address |
| bus_data | input | 8 | Bus data, low byte |
| mem_rd_n | input | 1 | Active-low memory read strobe |
| mem_wr_n | input | 1 | Active-low memory write strobe |
| flash_cs_n | output | 8 | Active-low flash chip selects |
| flash_addr | output | 21 | Flash address: page in 20:13, offset in 12:0 |

## Verification
The bench probes the window edges C7FFFh, C8000h, C9FFFh and CA000h. A decoder using too few address bits would select a device at one of the neighbours, or miss a window edge. It holds writes for several cycles while changing the data. A design that committed on the falling strobe, or on every low cycle, would show the new page too early or latch the wrong byte. It also writes to near-miss locations (CA002h, CA802h), to the window itself, and with junk in data bits 7:3 of a device write. A loose control decode or an unmasked device field would then move the page or select a wrong or non-existent chip.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  // Kind of page-control location hit by a bus address
  typedef enum logic [1:0] {
    CTRL_NONE = 2'd0,
    CTRL_PAGE = 2'd1,
    CTRL_DEV  = 2'd2
  } ctrl_e;
endpackage

// File: rtl/pfw_bus_sampler.sv
module pfw_bus_sampler #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              mem_rd_n,
  input  logic              mem_wr_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic              s_access,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_data,
  output logic              wr_release
);
  logic [DATA_W-1:0] s_data;
  logic              s_rd_n, s_wr_n, p_wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_addr <= '0;
      s_data <= '0;
      s_rd_n <= 1'b1;
      s_wr_n <= 1'b1;
      p_addr <= '0;
      p_data <= '0;
      p_wr_n <= 1'b1;
    end else begin
      s_addr <= bus_addr;
      s_data <= bus_data;
      s_rd_n <= mem_rd_n;
      s_wr_n <= mem_wr_n;
      p_addr <= s_addr;
      p_data <= s_data;
      p_wr_n <= s_wr_n;
    end
  end

  // Event wires for downstream logic and assertions
  assign s_access   = !s_rd_n || !s_wr_n;
  assign wr_release = !p_wr_n && s_wr_n;
endmodule

// File: rtl/pfw_page_regs.sv
module pfw_page_regs
  import pfw_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 8,
  parameter int              PAGE_W    = 8,
  parameter int              DEV_W     = 3,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 20'hCA000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_release,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_data,
  output logic [PAGE_W-1:0] page_q,
  output logic [DEV_W-1:0]  dev_q,
  output logic              commit_pg,
  output logic              commit_dev
);
  function automatic ctrl_e ctrl_kind(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:1] != CTRL_BASE[ADDR_W-1:1]) return CTRL_NONE;
    return a[0] ? CTRL_DEV : CTRL_PAGE;
  endfunction

  ctrl_e kind;
  assign kind       = ctrl_kind(p_addr);
  assign commit_pg  = wr_release && (kind == CTRL_PAGE);
  assign commit_dev = wr_release && (kind == CTRL_DEV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      dev_q  <= '0;
    end else begin
      if (commit_pg)  page_q <= p_data[PAGE_W-1:0];
      if (commit_dev) dev_q  <= p_data[DEV_W-1:0];
    end
  end

  // R5 R8
  page_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_q) |-> $past(commit_pg));
  // R6 R8
  dev_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_q) |-> $past(commit_dev));
  // R7
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pg && commit_dev));
endmodule

// File: rtl/pfw_select_gen.sv
module pfw_select_gen #(
  parameter int              HI_W     = 7,
  parameter int              NUM_DEV  = 8,
  parameter int              DEV_W    = 3,
  parameter logic [HI_W-1:0] WIN_TAG  = 7'h64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HI_W-1:0]    s_addr_hi,
  input  logic               s_access,
  input  logic [DEV_W-1:0]   dev_q,
  output logic               win_hit,
  output logic [NUM_DEV-1:0] cs_n
);
  assign win_hit = (s_addr_hi == WIN_TAG);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    assign cs_n[i] = !(s_access && win_hit && (dev_q == DEV_W'(i)));
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R2
  cs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_access && win_hit) |-> ($countones(~cs_n) == 1 && !cs_n[dev_q]));
  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_access |-> (&cs_n));
endmodule

// File: rtl/pfw_window_dec.sv
module pfw_window_dec #(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 8,
  parameter int              NUM_DEV   = 8,
  parameter int              OFF_W     = 13,
  parameter int              PAGE_W    = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC8000,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 20'hCA000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_data,
  input  logic                    mem_rd_n,
  input  logic                    mem_wr_n,
  output logic [NUM_DEV-1:0]      flash_cs_n,
  output logic [OFF_W+PAGE_W-1:0] flash_addr
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int HI_W  = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] s_addr, p_addr;
  logic [DATA_W-1:0] p_data;
  logic              s_access, wr_release, win_hit;
  logic              commit_pg, commit_dev;
  logic [PAGE_W-1:0] page_q;
  logic [DEV_W-1:0]  dev_q;

  pfw_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .s_addr(s_addr),
    .s_access(s_access), .p_addr(p_addr), .p_data(p_data),
    .wr_release(wr_release)
  );

  pfw_page_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .DEV_W(DEV_W),
    .CTRL_BASE(CTRL_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_release(wr_release), .p_addr(p_addr),
    .p_data(p_data), .page_q(page_q), .dev_q(dev_q),
    .commit_pg(commit_pg), .commit_dev(commit_dev)
  );

  pfw_select_gen #(
    .HI_W(HI_W), .NUM_DEV(NUM_DEV), .DEV_W(DEV_W),
    .WIN_TAG(WIN_BASE[ADDR_W-1:OFF_W])
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .s_addr_hi(s_addr[ADDR_W-1:OFF_W]),
    .s_access(s_access), .dev_q(dev_q), .win_hit(win_hit), .cs_n(flash_cs_n)
  );

  assign flash_addr = {page_q, s_addr[OFF_W-1:0]};

  // R3
  cs_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (&flash_cs_n));
  // R5 R6
  commit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pg || commit_dev) |-> wr_release);
endmodule

// File: tb/tb_pfw_window_dec.sv
`timescale 1ns/1ps
module tb_pfw_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        mem_rd_n = 1'b1, mem_wr_n = 1'b1;
  logic [7:0]  flash_cs_n;
  logic [20:0] flash_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfw_window_dec dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .flash_cs_n(flash_cs_n), .flash_addr(flash_addr)
  );

  // Behavioural reference: history of what the bus showed at each edge
  integer m_page, m_dev;
  integer h_addr[$], h_data[$], h_wr[$], h_rd[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_page = 0; m_dev = 0;
      h_addr = {0, 0}; h_data = {0, 0}; h_wr = {1, 1}; h_rd = {1, 1};
    end else begin
      // h_*[1] = latest sampled cycle, h_*[0] = the one before
      if (h_wr[0] == 0 && h_wr[1] == 1) begin
        if (h_addr[0] == 'hCA000) m_page = h_data[0] % 256;
        else if (h_addr[0] == 'hCA001) m_dev = h_data[0] % 8;
      end
      void'(h_addr.pop_front()); h_addr.push_back(bus_addr);
      void'(h_data.pop_front()); h_data.push_back(bus_data);
      void'(h_wr.pop_front());   h_wr.push_back(mem_wr_n);
      void'(h_rd.pop_front());   h_rd.push_back(mem_rd_n);
    end
  end

  function automatic logic [7:0] exp_cs();
    bit acc = (h_rd[1] == 0) || (h_wr[1] == 0);
    if (acc && (h_addr[1] / 8192) == 'h64) return ~(8'd1 << m_dev);
    return 8'hFF;
  endfunction

  function automatic logic [20:0] exp_fa();
    return 21'(m_page * 8192 + (h_addr[1] % 8192));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(flash_cs_n === exp_cs(), "R2 R3 chip select", 32'(flash_cs_n), 32'(exp_cs()));
    chk(flash_addr === exp_fa(), "R4 R5 R6 flash address", 32'(flash_addr), 32'(exp_fa()));
  endtask

  // Drive one bus state right after a falling edge and hold it n cycles
  task automatic step(input logic [19:0] a, input logic [7:0] d, input bit rd, input bit wr, input int n);
    bus_addr = a; bus_data = d; mem_rd_n = rd; mem_wr_n = wr;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic idle(input int n);
    step(20'hC8000, 8'h00, 1'b1, 1'b1, n);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(flash_cs_n == 8'hFF, "R1 cs after reset", 32'(flash_cs_n), 32'hFF);
    chk(flash_addr == 21'h0, "R1 addr after reset", 32'(flash_addr), 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 R4: read inside window, device 0
    step(20'hC8123, 8'h00, 1'b0, 1'b1, 2);
    chk(flash_cs_n == 8'hFE, "R2 read dev0", 32'(flash_cs_n), 32'hFE);
    chk(flash_addr == 21'h0123, "R4 offset", 32'(flash_addr), 32'h0123);
    idle(1);

    // R8 then R5: held write to page register, data changes while low
    step(20'hCA000, 8'h11, 1'b1, 1'b0, 2);
    step(20'hCA000, 8'h5A, 1'b1, 1'b0, 2);
    chk(flash_addr[20:13] == 8'h00, "R8 page held during write", 32'(flash_addr[20:13]), 32'h0);
    step(20'hC8000, 8'hEE, 1'b1, 1'b1, 1);
    chk(flash_addr[20:13] == 8'h00, "R5 not yet committed", 32'(flash_addr[20:13]), 32'h0);
    idle(1);
    chk(flash_addr[20:13] == 8'h5A, "R5 page committed", 32'(flash_addr[20:13]), 32'h5A);

    // R6: device write with junk in upper bits
    step(20'hCA001, 8'hFD, 1'b1, 1'b0, 2);
    idle(2);
    step(20'hC9FFF, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_cs_n == 8'hDF, "R6 dev5 selected", 32'(flash_cs_n), 32'hDF);
    chk(flash_addr == {8'h5A, 13'h1FFF}, "R5 R4 window top", 32'(flash_addr), 32'(21'h0B5FFF));
    idle(1);

    // R7: accesses that must not touch the registers
    step(20'hCA000, 8'h77, 1'b0, 1'b1, 2);
    chk(flash_cs_n == 8'hFF, "R3 read of control", 32'(flash_cs_n), 32'hFF);
    idle(1);
    step(20'hCA002, 8'h11, 1'b1, 1'b0, 2); idle(2);
    step(20'hCA802, 8'h22, 1'b1, 1'b0, 2); idle(2);
    step(20'hCA801, 8'h02, 1'b1, 1'b0, 2); idle(2);
    step(20'hC8000, 8'h33, 1'b1, 1'b0, 2);
    chk(flash_cs_n == 8'hDF, "R2 write in window", 32'(flash_cs_n), 32'hDF);
    idle(2);
    step(20'hC8010, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_addr[20:13] == 8'h5A, "R7 page unchanged", 32'(flash_addr[20:13]), 32'h5A);
    chk(flash_cs_n == 8'hDF, "R7 device unchanged", 32'(flash_cs_n), 32'hDF);
    idle(1);

    // R3: boundaries and idle strobes
    step(20'hC7FFF, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_cs_n == 8'hFF, "R3 below window", 32'(flash_cs_n), 32'hFF);
    step(20'hCA001, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_cs_n == 8'hFF, "R3 above window", 32'(flash_cs_n), 32'hFF);
    step(20'h48000, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_cs_n == 8'hFF, "R3 alias low", 32'(flash_cs_n), 32'hFF);
    step(20'hC8000, 8'h00, 1'b1, 1'b1, 1);
    chk(flash_cs_n == 8'hFF, "R3 no strobe", 32'(flash_cs_n), 32'hFF);
    step(20'hC8000, 8'h00, 1'b0, 1'b1, 1);
    chk(flash_cs_n == 8'hDF, "R3 window base", 32'(flash_cs_n), 32'hDF);

    // R2 R5 R6: sweep devices and pages; address moves as strobe releases
    for (int dv = 0; dv < 8; dv++) begin
      step(20'hCA001, 8'(dv + 8 * dv), 1'b1, 1'b0, 1);
      step(20'hCA000, 8'(dv * 37 + 1), 1'b1, 1'b1, 1);
      step(20'hCA000, 8'(dv * 37 + 1), 1'b1, 1'b0, 3);
      step(20'hB0000, 8'h00, 1'b1, 1'b1, 2);
      step(20'(32'hC8000 + dv * 997), 8'h00, 1'b0, 1'b1, 1);
      chk(flash_cs_n == ~(8'd1 << dv), "R2 R6 sweep cs", 32'(flash_cs_n), 32'(~(8'd1 << dv)));
      chk(flash_addr[20:13] == 8'(dv * 37 + 1), "R5 sweep page", 32'(flash_addr[20:13]), 32'(8'(dv * 37 + 1)));
      idle(1);
    end

    // R1: reset again clears registers
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(flash_addr == 21'h0, "R1 re-reset", 32'(flash_addr), 32'h0);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule